// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block relocates every memory access of a running process. A program address `a` is turned into a physical address `p = a - S + B`, where `S` is the address the program was compiled to start at and `B` is the physical base allotted to the process. The result is then checked against the allotted window `[B, L]`, where `L` is the physical limit. A request that lands inside the window comes back one cycle later with a valid strobe. A request that lands outside it, or whose arithmetic wraps, comes back with a fault strobe instead. The program address that caused the fault is latched for the operating system to read.

The three relocation registers are loaded through a small register-write port. That port only accepts writes while the processor is in kernel mode. A write attempted from user mode is discarded and answered with a protection-fault pulse. Requests issued in kernel mode bypass relocation and checking and leave with the address unchanged. Requests issued in user mode are always translated and checked, without exception.

Top module: `relo_unit`

## Requirements
- R1: A user-mode request with program address `a` returns, on the next cycle, `rsp_valid`=1 and `rsp_paddr = a - S + B`, provided that no wrap occurs and `B <= p <= L`.
- R2: A user-mode request whose translated address exceeds the limit `L` returns `rsp_fault`=1 and `rsp_valid`=0 on the next cycle.
- R3: A user-mode request whose sum `(a - S) + B` carries beyond the address width faults. The truncated result then lies below the base `B`.
- R4: A user-mode request with `a < S` (the subtraction borrows) faults.
- R5: A kernel-mode request returns `rsp_valid`=1 and `rsp_paddr = a` on the next cycle, whatever the register contents.
- R6: `rsp_valid` and `rsp_fault` are never both high. Neither is high unless `req_valid` was high one cycle earlier.
- R7: On a fault, `rsp_paddr` reads zero and `fault_addr` takes the offending program address one cycle after the request. `fault_addr` holds that value until the next fault.
- R8: A kernel-mode write with `cfg_sel` = 0 loads `S`, with 1 loads `B`, and with 2 loads `L`. A write with `cfg_sel` = 3 changes nothing. A loaded value applies to requests from the following cycle on.
- R9: A user-mode write changes no register and raises `gp_fault` for exactly one cycle, on the cycle after the write.
- R10: After reset, `S`, `B`, `L`, `fault_addr` and all response outputs are zero.
- R11: `rsp_write` repeats the `req_write` flag of the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| kernel_mode | input | 1 | Current privilege: 1 = kernel, 0 = user |
| cfg_wr_en | input | 1 | Register-write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 base, 2 limit, 3 none |
| cfg_wdata | input | AW | Register-write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | AW | Program address of the access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Translated access accepted |
| rsp_fault | output | 1 | Access out of bounds |
| rsp_paddr | output | AW | Physical address (zero on fault) |
| rsp_write | output | 1 | Read/write flag of the answered request |
| fault_addr | output | AW | Program address of the latest faulting access |
| gp_fault | output | 1 | Pulse: register write attempted from user mode |

## Verification
Two functions can fire in the same cycle: the protection fault of a refused register write, and the response to an access request. The bench provokes this by asserting a user-mode write and a user-mode request on the same clock edge. It does this once with an in-bounds address and once with an out-of-bounds one. It then checks that `gp_fault` and the access strobe both appear on the next cycle, that the write left the registers unchanged, and that a later request still uses the old register values.

// File: rtl/relo_pkg.sv
// Shared definitions for the relocation unit.
// Assumes: three relocation registers, selected by a 2-bit code.
package relo_pkg;
    localparam int REG_COUNT = 3;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_NONE  = 2'd3
    } relo_sel_e;
endpackage

// File: rtl/relo_regfile.sv
// Holds the program start, physical base and physical limit registers.
// Kernel-mode writes load the selected register. A user-mode write is
// dropped and flagged as a protection fault on the next cycle.
// Assumes: kernel_mode is stable during the write cycle.
module relo_regfile
    import relo_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kernel_mode,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          gp_fault
);
    logic [AW-1:0] regs_q [REG_COUNT];
    logic          wr_ok;

    // Purpose: a write is legal only in kernel mode
    assign wr_ok = cfg_wr_en && kernel_mode;

    for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
        // Purpose: load one relocation register when it is selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[gi] <= '0;
            else if (wr_ok && (cfg_sel == 2'(gi)))
                regs_q[gi] <= cfg_wdata;
        end
    end

    // Purpose: one-cycle pulse for a refused user-mode write
    always_ff @(posedge clk) begin
        if (!rst_n)
            gp_fault <= 1'b0;
        else
            gp_fault <= cfg_wr_en && !kernel_mode;
    end

    assign start_q = regs_q[SEL_START];
    assign base_q  = regs_q[SEL_BASE];
    assign limit_q = regs_q[SEL_LIMIT];

    AST_USER_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !kernel_mode) |=> ($stable(start_q) && $stable(base_q) && $stable(limit_q))); // R9
    AST_USER_WRITE_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !kernel_mode) |=> gp_fault); // R9
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(start_q) && $stable(base_q) && $stable(limit_q))); // R8
endmodule

// File: rtl/relo_xlate.sv
// Combinational relocation and bounds check for one access.
// Computes p = a - start + base with one extra bit, so that a borrow
// or a carry is visible, and compares p against [base, limit].
// Kernel-mode accesses pass through unchanged and never fault.
// Assumes: the registers are stable during the evaluating cycle.
module relo_xlate #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          kernel_mode,
    input  logic [AW-1:0] start_q,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] limit_q,
    output logic [AW-1:0] paddr,
    output logic          oob
);
    localparam int EW = AW + 1;

    logic [EW-1:0] offset_x;
    logic [EW-1:0] sum_x;
    logic          borrow;
    logic          carry;
    logic [AW-1:0] phys;
    logic          above;
    logic          below;

    // Purpose: subtract the compiled start, then add the physical base
    always_comb begin
        offset_x = {1'b0, addr} - {1'b0, start_q};
        borrow   = offset_x[AW];
        sum_x    = {1'b0, offset_x[AW-1:0]} + {1'b0, base_q};
        carry    = sum_x[AW];
        phys     = sum_x[AW-1:0];
    end

    // Purpose: compare the translated address with both window edges
    always_comb begin
        above = phys > limit_q;
        below = phys < base_q;
    end

    // Purpose: choose bypass or checked result
    always_comb begin
        if (kernel_mode) begin
            paddr = addr;
            oob   = 1'b0;
        end else begin
            oob   = borrow || carry || above || below;
            paddr = oob ? '0 : phys;
        end
    end

    AST_BORROW_FAULTS: assert final (kernel_mode || !(addr < start_q) || oob); // R4
endmodule

// File: rtl/relo_resp.sv
// Registers the translation result, producing a valid or fault strobe
// one cycle after the request, and latches the faulting program address.
// Assumes: oob and paddr come from the same request that req_valid marks.
module relo_resp #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] paddr,
    input  logic          oob,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_write,
    output logic [AW-1:0] fault_addr
);
    // Purpose: register the strobes and the response payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_write <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !oob;
            rsp_fault <= req_valid && oob;
            rsp_paddr <= req_valid ? paddr : '0;
            rsp_write <= req_valid && req_write;
        end
    end

    // Purpose: keep the program address of the latest fault
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_addr <= '0;
        else if (req_valid && oob)
            fault_addr <= req_addr;
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault)); // R6
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_fault)); // R6
    AST_FAULT_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && oob) |=> (fault_addr == $past(req_addr))); // R7
    AST_FAULT_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && oob) |=> $stable(fault_addr)); // R7
endmodule

// File: rtl/relo_unit.sv
// Top of the base-limit relocation unit. It ties together the privileged
// register file, the combinational translator and the response register.
// Assumes: one request per cycle at most, with a one-cycle fixed latency.
module relo_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kernel_mode,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_write,
    output logic [AW-1:0] fault_addr,
    output logic          gp_fault
);
    logic [AW-1:0] start_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic [AW-1:0] xl_paddr;
    logic          xl_oob;

    relo_regfile #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .kernel_mode(kernel_mode),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .start_q    (start_q),
        .base_q     (base_q),
        .limit_q    (limit_q),
        .gp_fault   (gp_fault)
    );

    relo_xlate #(.AW(AW)) u_xlate (
        .addr       (req_addr),
        .kernel_mode(kernel_mode),
        .start_q    (start_q),
        .base_q     (base_q),
        .limit_q    (limit_q),
        .paddr      (xl_paddr),
        .oob        (xl_oob)
    );

    relo_resp #(.AW(AW)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .paddr      (xl_paddr),
        .oob        (xl_oob),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_paddr  (rsp_paddr),
        .rsp_write  (rsp_write),
        .fault_addr (fault_addr)
    );

    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kernel_mode && !xl_oob) |=>
            (rsp_paddr >= $past(base_q) && rsp_paddr <= $past(limit_q))); // R1
    AST_KERNEL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kernel_mode) |=> (rsp_valid && rsp_paddr == $past(req_addr))); // R5
    AST_WRITE_FLAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_write == $past(req_write))); // R11
endmodule

// File: tb/relo_unit_bench.sv
`timescale 1ns/1ps
module relo_unit_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kernel_mode = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          rsp_valid, rsp_fault, rsp_write, gp_fault;
    logic [AW-1:0] rsp_paddr, fault_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    relo_unit #(.AW(AW)) u_relo_unit (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_write(rsp_write), .fault_addr(fault_addr), .gp_fault(gp_fault)
    );

    // Vectors with S=0x1000, B=0x4000, L=0x4FFF: address, write, fault, paddr
    localparam int NV = 6;
    localparam logic [AW-1:0] V_ADDR  [NV] = '{16'h1000, 16'h1FFF, 16'h1800, 16'h2000, 16'h0FFF, 16'hFFFF};
    localparam logic          V_WR    [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic          V_FAULT [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [AW-1:0] V_PADDR [NV] = '{16'h4000, 16'h4FFF, 16'h4800, 16'h0000, 16'h0000, 16'h0000};
    localparam string         V_REQ   [NV] = '{"R1", "R1", "R11", "R2", "R4", "R2"};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit kern, input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        kernel_mode = kern; cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; kernel_mode = 1'b0;
    endtask

    // Issue one request and check its response one cycle later
    task automatic access(input bit kern, input logic [AW-1:0] a, input bit wr,
                          input bit exp_fault, input logic [AW-1:0] exp_pa, input string req);
        @(negedge clk);
        kernel_mode = kern; req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; kernel_mode = 1'b0;
        check(rsp_valid == !exp_fault, req, "valid", 32'(rsp_valid), 32'(!exp_fault));
        check(rsp_fault == exp_fault, req, "fault", 32'(rsp_fault), 32'(exp_fault));
        check(rsp_paddr == exp_pa, req, "paddr", 32'(rsp_paddr), 32'(exp_pa));
        check(rsp_write == wr, "R11", "write flag", 32'(rsp_write), 32'(wr));
        if (exp_fault)
            check(fault_addr == a, "R7", "fault_addr", 32'(fault_addr), 32'(a));
    endtask

    task automatic load_regs(input logic [AW-1:0] s, input logic [AW-1:0] b, input logic [AW-1:0] l);
        cfg_write(1'b1, 2'd0, s);
        cfg_write(1'b1, 2'd1, b);
        cfg_write(1'b1, 2'd2, l);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(rsp_valid == 0 && rsp_fault == 0 && gp_fault == 0, "R10", "strobes",
              {29'd0, rsp_valid, rsp_fault, gp_fault}, 32'd0);
        check(rsp_paddr == 0 && fault_addr == 0, "R10", "addresses",
              {rsp_paddr, fault_addr}, 32'd0);
        rst_n = 1'b1;
        // R10: zero registers -> address 0 maps to 0 inside [0,0]
        access(1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, "R10");
        access(1'b0, 16'h0001, 1'b0, 1'b1, 16'h0000, "R10");

        load_regs(16'h1000, 16'h4000, 16'h4FFF);  // R8
        for (int i = 0; i < NV; i++)
            access(1'b0, V_ADDR[i], V_WR[i], V_FAULT[i], V_PADDR[i], V_REQ[i]);

        // R7: fault_addr holds through a good access
        access(1'b0, 16'h1004, 1'b0, 1'b0, 16'h4004, "R7");
        check(fault_addr == 16'hFFFF, "R7", "fault_addr held", 32'(fault_addr), 32'hFFFF);

        // R5: kernel bypass, even for an out-of-window address
        access(1'b1, 16'h0123, 1'b1, 1'b0, 16'h0123, "R5");
        access(1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF, "R5");

        // R6: no strobe without request
        @(negedge clk);
        check(!rsp_valid && !rsp_fault, "R6", "idle strobes", {30'd0, rsp_valid, rsp_fault}, 32'd0);

        // R9: user write refused, pulse for one cycle, registers unchanged
        cfg_write(1'b0, 2'd1, 16'h8000);
        check(gp_fault == 1'b1, "R9", "gp pulse", 32'(gp_fault), 32'd1);
        @(negedge clk);
        check(gp_fault == 1'b0, "R9", "gp one cycle", 32'(gp_fault), 32'd0);
        access(1'b0, 16'h1000, 1'b0, 1'b0, 16'h4000, "R9");

        // R8: select 3 changes nothing
        cfg_write(1'b1, 2'd3, 16'h0000);
        access(1'b0, 16'h1FFF, 1'b0, 1'b0, 16'h4FFF, "R8");
        // R8: new limit applies on the next request
        cfg_write(1'b1, 2'd2, 16'h47FF);
        access(1'b0, 16'h1800, 1'b0, 1'b1, 16'h0000, "R8");
        access(1'b0, 16'h17FF, 1'b0, 1'b0, 16'h47FF, "R8");

        // R3: sum carries past the address width, truncated result below base
        load_regs(16'h0000, 16'hF000, 16'hFFFF);
        access(1'b0, 16'h2000, 1'b0, 1'b1, 16'h0000, "R3");
        access(1'b0, 16'h0FFF, 1'b0, 1'b0, 16'hFFFF, "R1");

        // Collision: user write and user request on the same edge
        @(negedge clk);
        kernel_mode = 1'b0; cfg_wr_en = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'h0000;
        req_valid = 1'b1; req_addr = 16'h0010; req_write = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0;
        check(gp_fault && rsp_valid && !rsp_fault, "R9", "gp with valid",
              {29'd0, gp_fault, rsp_valid, rsp_fault}, 32'd6);
        check(rsp_paddr == 16'hF010, "R1", "paddr with gp", 32'(rsp_paddr), 32'hF010);
        @(negedge clk);
        kernel_mode = 1'b0; cfg_wr_en = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'hFFFF;
        req_valid = 1'b1; req_addr = 16'h3000; req_write = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0;
        check(gp_fault && rsp_fault && !rsp_valid, "R6", "gp with fault",
              {29'd0, gp_fault, rsp_valid, rsp_fault}, 32'd5);
        check(fault_addr == 16'h3000, "R7", "fault_addr in collision", 32'(fault_addr), 32'h3000);
        access(1'b0, 16'h0020, 1'b0, 1'b0, 16'hF020, "R9");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule